// File: doc/BRIEF.md
# Snooze Power-Down Sequencer

This block steps a synchronous memory into and out of a low-power snooze state. The request comes from a sleep pin that is asynchronous and active high; the memory stays asleep for as long as the pin stays high. The block first passes the pin through a chain of synchronizing flops. It then closes the command-sampling gate and puts the data outputs in high impedance. After a fixed entry window it reports the reduced-power state. While asleep the stored data is kept and every input except the sleep pin is ignored.

When the pin drops, the block opens the sampling gate again after the synchronizer delay. A fixed recovery window follows, and in it only deselect and read commands are legal. A write seen in that window sets a sticky violation flag. So does a sleep request that reaches the machine while a read or write is still being issued, because such an operation may not complete.

Each cycle the command class is presented on a two-bit code: 2'b00 deselect, 2'b01 read, 2'b10 write, 2'b11 reserved and treated as deselect.

Top module: `snooze_seq`

## Requirements
- R1: During reset and after it, `in_gate_en`=1, `out_hiz`=0, `low_power`=0 and `violation`=0.
- R2: Number the clock edges from the first edge that samples `sleep_pin` high as edge 0. `in_gate_en` falls and `out_hiz` rises after edge 2, and neither output changes before that.
- R3: `low_power` rises after edge 4, which is two cycles after the gate closed.
- R4: While `low_power`=1, `in_gate_en`=0 and `out_hiz`=1, and the state holds for as long as the pin stays high.
- R5: Number the clock edges from the first edge that samples `sleep_pin` low during sleep as edge 0. `low_power` falls, `in_gate_en` rises and `out_hiz` falls after edge 2. The next two cycles form the recovery window.
- R6: A write command (2'b10) sampled during the recovery window sets `violation`. A read (2'b01), a deselect (2'b00) or the reserved code (2'b11) sampled there does not set it.
- R7: If the synchronized sleep request reaches the idle machine on an edge where the command is a read or a write, `violation` is set. With a deselect on that edge it is not set.
- R8: `violation` stays set until reset.
- R9: A write sampled after the recovery window has ended does not set `violation`.
- R10: Once entry has begun it always completes. A pin pulse that is high on a single sampling edge still gives one cycle of `low_power` (after edge 4), then `low_power` falls after edge 5 and recovery follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_pin | input | 1 | Asynchronous sleep request, active high |
| cmd | input | 2 | Command class: 00 deselect, 01 read, 10 write, 11 reserved |
| in_gate_en | output | 1 | High when command inputs may be sampled |
| out_hiz | output | 1 | High when the data outputs must be high impedance |
| low_power | output | 1 | High while in the reduced-power state |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume that `cmd` holds a defined two-bit value on every edge, including edges where the gate is closed. The pin itself may change at any time. The bench changes `sleep_pin` and `cmd` only on falling clock edges, so each value is seen by exactly one known rising edge, and it keeps every command at one of the four defined codes. It starts each scenario from a fresh reset, so that the violation flag left by one scenario does not hide the result of the next.

// File: rtl/snooze_seq.sv
module snooze_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_CYC   = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_pin,
  input  logic [1:0] cmd,
  output logic       in_gate_en,
  output logic       out_hiz,
  output logic       low_power,
  output logic       violation
);
  localparam int MAXC  = (ENTER_CYC > RECOV_CYC) ? ENTER_CYC : RECOV_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ENTER_LAST = CNT_W'(ENTER_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_CYC - 1);

  typedef enum logic [1:0] {ST_ACTIVE, ST_ENTER, ST_SLEEP, ST_RECOV} st_t;

  logic [SYNC_STAGES-1:0] sync_q;
  st_t                    st;
  logic [CNT_W-1:0]       cnt;
  logic                   slp, is_rd, is_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= sleep_pin;

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[i] <= 1'b0;
      else        sync_q[i] <= sync_q[i-1];
  end

  assign slp   = sync_q[SYNC_STAGES-1];
  assign is_rd = (cmd == 2'b01);
  assign is_wr = (cmd == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_ACTIVE;
      cnt <= '0;
    end else begin
      case (st)
        ST_ACTIVE: if (slp) begin st <= ST_ENTER; cnt <= '0; end
        ST_ENTER:
          if (cnt == ENTER_LAST) st <= ST_SLEEP;
          else                   cnt <= cnt + 1'b1;
        ST_SLEEP: if (!slp) begin st <= ST_RECOV; cnt <= '0; end
        ST_RECOV:
          if (slp) begin
            st  <= ST_ENTER;
            cnt <= '0;
          end else if (cnt == RECOV_LAST) st <= ST_ACTIVE;
          else                            cnt <= cnt + 1'b1;
        default: st <= ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) violation <= 1'b0;
    else if ((st == ST_ACTIVE && slp && (is_rd || is_wr)) ||
             (st == ST_RECOV && is_wr))
      violation <= 1'b1;

  assign in_gate_en = (st == ST_ACTIVE) || (st == ST_RECOV);
  assign out_hiz    = (st == ST_ENTER)  || (st == ST_SLEEP);
  assign low_power  = (st == ST_SLEEP);
endmodule

// File: rtl/snooze_seq_chk.sv
module snooze_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic in_gate_en,
  input logic out_hiz,
  input logic low_power,
  input logic violation
);
  // R4
  asleep_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (!in_gate_en && out_hiz));

  // R8
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  // R3
  sleep_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_power) |-> $past(out_hiz));

  // R10
  entry_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hiz && !low_power) |=> out_hiz);

  // R5
  wake_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_power) |-> (in_gate_en && !out_hiz));

  // R1
  gate_hiz_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_gate_en != out_hiz);
endmodule

bind snooze_seq snooze_seq_chk u_snooze_seq_chk (
  .clk(clk), .rst_n(rst_n), .in_gate_en(in_gate_en),
  .out_hiz(out_hiz), .low_power(low_power), .violation(violation)
);

// File: tb/test_snooze_seq.sv
module test_snooze_seq;
  logic clk = 1'b0, rst_n = 1'b0, sleep_pin = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic in_gate_en, out_hiz, low_power, violation;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  snooze_seq i_snooze_seq (
    .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .cmd(cmd),
    .in_gate_en(in_gate_en), .out_hiz(out_hiz),
    .low_power(low_power), .violation(violation)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: gate/hiz/lp/viol actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {in_gate_en, out_hiz, low_power, violation};
  endfunction

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sleep_pin = 1'b0; cmd = 2'b00;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic go_sleep();
    sleep_pin = 1'b1;
    step(5);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(1);
    chk("R1 in reset", outs(), 4'b1000);
    rst_n = 1'b1;
    step(2);
    chk("R1 after reset", outs(), 4'b1000);
  endtask

  task automatic t_entry();
    do_reset();
    sleep_pin = 1'b1;
    step(2);
    chk("R2 before edge 2", outs(), 4'b1000);
    step(1);
    chk("R2 gate closed", outs(), 4'b0100);
    step(1);
    chk("R3 not yet low power", outs(), 4'b0100);
    step(1);
    chk("R3 low power", outs(), 4'b0110);
    cmd = 2'b10;
    step(6);
    chk("R4 held asleep, write ignored", outs(), 4'b0110);
    cmd = 2'b00;
  endtask

  task automatic t_exit_write();
    do_reset();
    go_sleep();
    sleep_pin = 1'b0;
    step(2);
    chk("R5 still asleep", outs(), 4'b0110);
    step(1);
    chk("R5 woken", outs(), 4'b1000);
    step(1);
    cmd = 2'b10;
    step(1);
    cmd = 2'b00;
    chk("R6 write in recovery", outs(), 4'b1001);
    step(4);
    chk("R8 sticky", outs(), 4'b1001);
    go_sleep();
    sleep_pin = 1'b0;
    step(5);
    chk("R8 sticky across sleep", outs(), 4'b1001);
  endtask

  task automatic t_exit_read();
    do_reset();
    go_sleep();
    sleep_pin = 1'b0;
    step(3);
    cmd = 2'b01;
    step(1);
    cmd = 2'b11;
    step(1);
    cmd = 2'b00;
    chk("R6 read/reserved in recovery", outs(), 4'b1000);
    cmd = 2'b10;
    step(1);
    cmd = 2'b00;
    chk("R9 write after recovery", outs(), 4'b1000);
  endtask

  task automatic t_pending();
    do_reset();
    sleep_pin = 1'b1;
    step(2);
    cmd = 2'b01;
    step(1);
    cmd = 2'b00;
    chk("R7 read while sleep seen", outs(), 4'b0101);
    sleep_pin = 1'b0;
    step(8);
    chk("R8 flag kept after wake", outs(), 4'b1001);
    do_reset();
    chk("R8 cleared by reset", outs(), 4'b1000);
    sleep_pin = 1'b1;
    step(3);
    chk("R7 deselect while sleep seen", outs(), 4'b0100);
    sleep_pin = 1'b0;
    step(8);
  endtask

  task automatic t_pulse();
    do_reset();
    sleep_pin = 1'b1;
    step(1);
    sleep_pin = 1'b0;
    step(3);
    chk("R10 entry continues", outs(), 4'b0100);
    step(1);
    chk("R10 one cycle low power", outs(), 4'b0110);
    step(1);
    chk("R10 recovery after pulse", outs(), 4'b1000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_entry();
        t_exit_write();
        t_exit_read();
        t_pending();
        t_pulse();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual expired expected done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule